// File: doc/BRIEF.md
# Channel Diagnosis Flag Latch and Encoder

This block watches the fault observations of eight low-side output channels and keeps a sticky record of each one until a completed serial frame has carried it away. Each channel records a protection fault (overload or overtemperature), a short to ground and an open load. The last two are judged only while the channel's gate is off, and only after the comparator has agreed for a set number of clock cycles in a row.

The recorded flags of each channel reduce to a 2-bit code. The eight codes are packed into a 16-bit diagnosis word, which the serial interface logic loads and shifts out. A separate status byte passes the live drain-level comparators straight through, with no latch in the path, so that software can see the present switch state.

A one-cycle clear pulse from the serial block, raised when a frame of valid length ends, wipes every stored flag. A fault seen in that same cycle survives the clear.

Top module: `diag_flag_encoder`

## Requirements
- R1: While reset is asserted, and right after it is released, every channel reports code 11, so the word is all ones.
- R2: Channel n drives bits 2n+1:2n of `diag_word`. The codes are: 00 short to ground, 01 open load, 10 protection fault, 11 no fault.
- R3: When `ovl_flag[n]` or `ovt_flag[n]` is high at a clock edge, channel n reports 10 after that edge. Either source alone is enough.
- R4: Open-load and short-to-ground observations are ignored in any cycle where `gate_on[n]` is high.
- R5: An off-state observation is latched only if it is sampled on FAULT_DLY consecutive edges. The code changes after the FAULT_DLY-th edge, and any break in the run restarts the count.
- R6: A latched flag stays set after its cause goes away, for as long as no clear pulse arrives.
- R7: A `frame_clr` pulse removes every latched flag, so a channel with no new cause reports 11 after that edge.
- R8: A cause that is present in the same cycle as `frame_clr` leaves its flag set.
- R9: When several flags are set, the code is chosen in this order: protection fault first, then short to ground, then open load.
- R10: `out_status` equals `drain_low` in the same cycle, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clr | input | 1 | One-cycle clear pulse from a completed serial frame |
| gate_on | input | 8 | Gate drive state per channel, 1 = on |
| ol_cmp | input | 8 | Off-state open-load comparator per channel |
| sg_cmp | input | 8 | Off-state short-to-ground comparator per channel |
| ovl_flag | input | 8 | Overload flag from protection per channel |
| ovt_flag | input | 8 | Overtemperature flag from protection per channel |
| drain_low | input | 8 | Live drain-level comparator per channel |
| diag_word | output | 16 | Packed 2-bit diagnosis codes, channel n at bits 2n+1:2n |
| out_status | output | 8 | Live output status byte |

## Verification
A flag that is set when it should be clear, or clear when it should be set, shows in that channel's bit pair of `diag_word` one edge after the cycle that caused it. A persistence counter that runs fast or slow moves the edge at which 11 turns into 01 or 00. So a fault is held for exactly FAULT_DLY samples, checked at FAULT_DLY-1 and at FAULT_DLY, and also broken one sample short. Faults that arrive together with a clear, and faults on the same channel that compete for the code, are driven on purpose, because a wrong priority or a lost flag shows only in those cycles.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef enum logic [1:0] {
    DC_SHORT_GND = 2'b00,
    DC_OPEN_LOAD = 2'b01,
    DC_PROT      = 2'b10,
    DC_NORMAL    = 2'b11
  } diag_code_e;

  // Priority: protection fault, then short to ground, then open load.
  function automatic diag_code_e pick_code(input logic prot, input logic sg, input logic ol);
    diag_code_e c;
    c = DC_NORMAL;
    if (ol)   c = DC_OPEN_LOAD;
    if (sg)   c = DC_SHORT_GND;
    if (prot) c = DC_PROT;
    return c;
  endfunction

  function automatic int unsigned hold_width(input int unsigned dly);
    return (dly > 1) ? $clog2(dly) : 1;
  endfunction

endpackage

// File: rtl/diag_persist.sv
module diag_persist #(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic qual
);
  localparam int unsigned CW = diag_pkg::hold_width(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;

  // Qualified on the DLY-th consecutive sampled edge and held while cond stays.
  assign qual = cond && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!cond)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/diag_sticky.sv
module diag_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;   // a new cause beats a clear
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/diag_channel.sv
module diag_channel #(
  parameter int unsigned FAULT_DLY = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 gate,
  input  logic                 ol_in,
  input  logic                 sg_in,
  input  logic                 ovl_in,
  input  logic                 ovt_in,
  output logic                 prot_hit,
  output logic                 ol_qual,
  output logic                 sg_qual,
  output logic                 prot_flag,
  output logic                 ol_flag,
  output logic                 sg_flag,
  output diag_pkg::diag_code_e code
);
  logic ol_off, sg_off;

  assign prot_hit = ovl_in | ovt_in;
  assign ol_off   = ol_in & ~gate;
  assign sg_off   = sg_in & ~gate;

  diag_persist #(.DLY(FAULT_DLY)) u_ol_hold (
    .clk(clk), .rst_n(rst_n), .cond(ol_off), .qual(ol_qual));
  diag_persist #(.DLY(FAULT_DLY)) u_sg_hold (
    .clk(clk), .rst_n(rst_n), .cond(sg_off), .qual(sg_qual));

  diag_sticky u_prot (.clk(clk), .rst_n(rst_n), .set(prot_hit), .clr(clr), .flag(prot_flag));
  diag_sticky u_ol   (.clk(clk), .rst_n(rst_n), .set(ol_qual),  .clr(clr), .flag(ol_flag));
  diag_sticky u_sg   (.clk(clk), .rst_n(rst_n), .set(sg_qual),  .clr(clr), .flag(sg_flag));

  assign code = diag_pkg::pick_code(prot_flag, sg_flag, ol_flag);
endmodule

// File: rtl/diag_flag_encoder.sv
module diag_flag_encoder #(
  parameter int unsigned NCH       = 8,
  parameter int unsigned FAULT_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic [NCH-1:0]   gate_on,
  input  logic [NCH-1:0]   ol_cmp,
  input  logic [NCH-1:0]   sg_cmp,
  input  logic [NCH-1:0]   ovl_flag,
  input  logic [NCH-1:0]   ovt_flag,
  input  logic [NCH-1:0]   drain_low,
  output logic [2*NCH-1:0] diag_word,
  output logic [NCH-1:0]   out_status
);
  // Named per-channel events, brought out for the checker.
  logic [NCH-1:0] prot_hit, ol_qual, sg_qual;
  logic [NCH-1:0] prot_flag, ol_flag, sg_flag;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    diag_pkg::diag_code_e code;
    diag_channel #(.FAULT_DLY(FAULT_DLY)) u_chan (
      .clk(clk), .rst_n(rst_n), .clr(frame_clr), .gate(gate_on[ch]),
      .ol_in(ol_cmp[ch]), .sg_in(sg_cmp[ch]),
      .ovl_in(ovl_flag[ch]), .ovt_in(ovt_flag[ch]),
      .prot_hit(prot_hit[ch]), .ol_qual(ol_qual[ch]), .sg_qual(sg_qual[ch]),
      .prot_flag(prot_flag[ch]), .ol_flag(ol_flag[ch]), .sg_flag(sg_flag[ch]),
      .code(code));
    assign diag_word[2*ch +: 2] = code;
  end

  assign out_status = drain_low;
endmodule

// File: rtl/diag_flag_encoder_chk.sv
module diag_flag_encoder_chk #(
  parameter int unsigned NCH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_clr,
  input logic [NCH-1:0]   gate_on,
  input logic [NCH-1:0]   ol_cmp,
  input logic [NCH-1:0]   sg_cmp,
  input logic [NCH-1:0]   prot_hit,
  input logic [NCH-1:0]   ol_qual,
  input logic [NCH-1:0]   sg_qual,
  input logic [NCH-1:0]   prot_flag,
  input logic [NCH-1:0]   ol_flag,
  input logic [NCH-1:0]   sg_flag,
  input logic [2*NCH-1:0] diag_word
);
  for (genvar n = 0; n < NCH; n++) begin : g_a
    assert_prot_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prot_hit[n] |=> diag_word[2*n +: 2] == 2'b10);
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_flag[n] || ol_flag[n] || sg_flag[n]) && !frame_clr |=>
        diag_word[2*n +: 2] != 2'b11);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_clr && !prot_hit[n] && !ol_qual[n] && !sg_qual[n] |=>
        diag_word[2*n +: 2] == 2'b11);
    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gate_on[n] |=> !$rose(ol_flag[n]) && !$rose(sg_flag[n]));
    assert_ol_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ol_flag[n]) |-> $past(ol_cmp[n] && !gate_on[n]));
    assert_sg_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sg_flag[n]) |-> $past(sg_cmp[n] && !gate_on[n]));
    assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sg_flag[n] && !prot_flag[n] |-> diag_word[2*n +: 2] == 2'b00);
  end
endmodule

bind diag_flag_encoder diag_flag_encoder_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .gate_on(gate_on),
  .ol_cmp(ol_cmp), .sg_cmp(sg_cmp), .prot_hit(prot_hit), .ol_qual(ol_qual),
  .sg_qual(sg_qual), .prot_flag(prot_flag), .ol_flag(ol_flag),
  .sg_flag(sg_flag), .diag_word(diag_word));

// File: tb/diag_flag_encoder_test.sv
module diag_flag_encoder_test;
  localparam int NCH = 8;
  localparam int DLY = 4;
  localparam int WW  = 2 * NCH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clr = 1'b0;
  logic [NCH-1:0] gate_on = '0, ol_cmp = '0, sg_cmp = '0;
  logic [NCH-1:0] ovl_flag = '0, ovt_flag = '0, drain_low = '0;
  logic [WW-1:0]  diag_word;
  logic [NCH-1:0] out_status;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  logic [WW-1:0] exp_q[$];
  string         tag_q[$];

  // Reference state kept by the bench.
  bit m_prot[NCH], m_ol[NCH], m_sg[NCH];
  int run_ol[NCH], run_sg[NCH];

  always #2 clk = ~clk;

  diag_flag_encoder #(.NCH(NCH), .FAULT_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .gate_on(gate_on),
    .ol_cmp(ol_cmp), .sg_cmp(sg_cmp), .ovl_flag(ovl_flag), .ovt_flag(ovt_flag),
    .drain_low(drain_low), .diag_word(diag_word), .out_status(out_status));

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs, predict the word seen after the next edge.
  task automatic drive(input logic [NCH-1:0] g, input logic [NCH-1:0] ol,
                       input logic [NCH-1:0] sg, input logic [NCH-1:0] ov,
                       input logic [NCH-1:0] ot, input logic clr, input string tag);
    logic [WW-1:0] e;
    @(negedge clk);
    gate_on = g; ol_cmp = ol; sg_cmp = sg; ovl_flag = ov; ovt_flag = ot; frame_clr = clr;
    e = '1;
    for (int n = 0; n < NCH; n++) begin
      bit ol_ok, sg_ok;
      ol_ok = 1'b0; sg_ok = 1'b0;
      if (ol[n] && !g[n]) begin
        run_ol[n]++;
        ol_ok = run_ol[n] >= DLY;
      end else run_ol[n] = 0;
      if (sg[n] && !g[n]) begin
        run_sg[n]++;
        sg_ok = run_sg[n] >= DLY;
      end else run_sg[n] = 0;
      m_prot[n] = (ov[n] || ot[n]) ? 1'b1 : (clr ? 1'b0 : m_prot[n]);
      m_ol[n]   = ol_ok ? 1'b1 : (clr ? 1'b0 : m_ol[n]);
      m_sg[n]   = sg_ok ? 1'b1 : (clr ? 1'b0 : m_sg[n]);
      if (m_prot[n])      e[2*n +: 2] = 2'b10;
      else if (m_sg[n])   e[2*n +: 2] = 2'b00;
      else if (m_ol[n])   e[2*n +: 2] = 2'b01;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), diag_word, exp_q.pop_front());
    end
  end

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) drive('0, '0, '0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NCH; n++) begin
      m_prot[n] = 0; m_ol[n] = 0; m_sg[n] = 0; run_ol[n] = 0; run_sg[n] = 0;
    end
    repeat (3) @(posedge clk);
    #1 check("R1 reset", diag_word, '1);
    @(negedge clk) rst_n = 1'b1;
    idle(1, "R1 after reset");

    // R10: status byte follows the drain comparator in the same cycle
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      drain_low = (p == 0) ? 8'hA5 : (p == 1) ? 8'h5A : (p == 2) ? 8'hFF : 8'h00;
      #1 check("R10 live status", {8'h00, out_status}, {8'h00, drain_low});
    end

    // R3 and R6: overload pulse on channel 2, overtemperature pulse on channel 5
    drive('0, '0, '0, 8'h04, '0, 1'b0, "R3 overload ch2");
    drive('0, '0, '0, '0, 8'h20, 1'b0, "R3 overtemp ch5");
    idle(3, "R6 sticky protection R2");

    // R7: clear
    drive('0, '0, '0, '0, '0, 1'b1, "R7 clear");
    idle(1, "R7 after clear");

    // R5: open load on channel 0, gate off, held DLY samples
    for (int i = 0; i < DLY; i++) drive('0, 8'h01, '0, '0, '0, 1'b0, "R5 open-load hold");
    idle(2, "R6 open-load sticky");
    drive('0, '0, '0, '0, '0, 1'b1, "R7 clear open-load");

    // R5: a break one sample short restarts the count
    for (int i = 0; i < DLY - 1; i++) drive('0, 8'h02, '0, '0, '0, 1'b0, "R5 run short");
    drive('0, '0, '0, '0, '0, 1'b0, "R5 break");
    for (int i = 0; i < DLY - 1; i++) drive('0, 8'h02, '0, '0, '0, 1'b0, "R5 restart");
    drive('0, 8'h02, '0, '0, '0, 1'b0, "R5 complete run");
    drive('0, '0, '0, '0, '0, 1'b1, "R7 clear");

    // R4: gate on masks off-state observations
    for (int i = 0; i < DLY + 2; i++) drive(8'hFF, 8'hF0, 8'h0F, '0, '0, 1'b0, "R4 gate on");

    // R9: short to ground beats open load on channel 3
    for (int i = 0; i < DLY; i++) drive('0, 8'h08, 8'h08, '0, '0, 1'b0, "R9 sg over ol");
    drive('0, '0, '0, 8'h08, '0, 1'b0, "R9 prot over sg");
    idle(1, "R9 hold");
    drive('0, '0, '0, '0, '0, 1'b1, "R7 clear");

    // R8: a cause together with the clear survives
    drive('0, '0, '0, 8'h80, '0, 1'b0, "R3 ch7");
    drive('0, '0, '0, 8'h80, 8'h01, 1'b1, "R8 set with clear");
    idle(1, "R8 kept");
    // R8: a qualified open load on the clear cycle survives
    for (int i = 0; i < DLY - 1; i++) drive('0, 8'h40, '0, '0, '0, 1'b0, "R5 ch6 run");
    drive('0, 8'h40, '0, '0, '0, 1'b1, "R8 qualify with clear");
    drive('0, '0, '0, '0, '0, 1'b1, "R7 final clear");
    idle(2, "R1 R2 quiet");

    while (exp_q.size() > 0) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule